// File: doc/BRIEF.md
# Hardware Ready-Queue Thread Scheduler

This block is a scheduling co-processor for a real-time kernel. It keeps the set of ready threads as a singly linked list. The list lives in on-chip tables indexed by thread ID, with a head pointer and a tail pointer. New threads are appended at the tail in arrival order, and nothing is sorted. The block always holds a precomputed "next thread to run" answer. When the kernel's timer fires, the host reads that answer at once and spends no time searching.

Two requesters issue commands: a thread-manager port and a general host command port. Both ports use the same request/acknowledge handshake. Each command either adds a thread (enqueue, with its priority) or removes one (dequeue).

- An enqueue costs a fixed, short time. It appends the thread and compares it once against the current choice.
- A dequeue walks the list from the head at one element per cycle. It unlinks the target and, in the same pass, re-elects the most urgent remaining thread.

Top module: `thread_ready_sched`

## Requirements
- R1: An enqueue of an absent thread appends it to the list. The new thread becomes the next choice (`next_tid`, `next_prio`, `next_valid`=1) if no choice exists or if its priority value is strictly lower than the current choice's. Lower value means more urgent. Thread IDs are 8 bits (0 to 255) and priorities are 7 bits (0 to 127).
- R2: On equal priority values, the thread that is earlier in list order stays or becomes the choice.
- R3: A dequeue of a queued thread removes it from the list. The next choice becomes the lowest-valued remaining thread, with the earliest in list order winning ties. The unlink is correct whether the target is the head, the tail or a middle element.
- R4: An enqueue of a thread that is already queued leaves the list and the choice unchanged. It completes with `cmd_err`=1 together with the acknowledge.
- R5: A dequeue of a thread that is not queued leaves the list and the choice unchanged. It completes with `cmd_err`=1 together with the acknowledge. This holds for an empty list and for a non-empty list.
- R6: After reset, and whenever the list becomes empty, `next_valid` is 0.
- R7: Handshake rules:
  - A request is accepted at a rising edge where the block is idle and no acknowledge is high.
  - `busy` is 1 from the cycle after acceptance until the acknowledge cycle.
  - The acknowledge is a single-cycle pulse on the requesting port, with `busy` at 0.
  - The requester holds its request until it sees the acknowledge.
  - Op encoding: 0 = enqueue, 1 = dequeue.
- R8: When both ports request in the same cycle, the thread-manager port is served first. The host request is accepted after the manager's acknowledge.
- R9: The acknowledge timing, counted from the accepting edge, is:
  - a successful enqueue acknowledges after the second following edge;
  - an erroring command acknowledges after the first following edge;
  - a successful dequeue acknowledges after 1+L following edges, where L is the list length before removal.
- R10: After reset, `busy`, `mgr_ack`, `host_ack` and `cmd_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mgr_req | input | 1 | Thread-manager command request |
| mgr_op | input | 1 | Manager op: 0 enqueue, 1 dequeue |
| mgr_tid | input | 8 | Manager thread ID |
| mgr_prio | input | 7 | Manager priority (enqueue only) |
| mgr_ack | output | 1 | Manager acknowledge pulse |
| host_req | input | 1 | Host command request |
| host_op | input | 1 | Host op: 0 enqueue, 1 dequeue |
| host_tid | input | 8 | Host thread ID |
| host_prio | input | 7 | Host priority (enqueue only) |
| host_ack | output | 1 | Host acknowledge pulse |
| cmd_err | output | 1 | Error status, valid with an acknowledge |
| busy | output | 1 | Command in progress |
| next_tid | output | 8 | Precomputed next thread ID |
| next_prio | output | 7 | Priority of the next thread |
| next_valid | output | 1 | A next thread exists |

## Verification
The acknowledge times are due as follows, counting edges from the one that accepts the request:
- a successful enqueue is due on the third edge;
- an erroring command is due on the second edge;
- a successful dequeue is due on edge L+2, where L is the model's list length before the removal.

The bench drives requests on falling edges and samples on the falling edge after each rising edge. It counts edges until an acknowledge appears and compares that count with the model's figure. At that same sample it compares `cmd_err` and the next-thread outputs, and `busy` must have been high at every sample before it. One further idle cycle confirms that the choice holds steady.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHK,
    ST_LINK,
    ST_WALK
  } sched_state_e;

  localparam logic OP_ENQ = 1'b0;
  localparam logic OP_DEQ = 1'b1;
endpackage

// File: rtl/sched_table.sv
module sched_table #(
  parameter int TID_W  = 8,
  parameter int PRIO_W = 7
) (
  input  logic              clk,
  input  logic [TID_W-1:0]  rd_addr,
  output logic [PRIO_W-1:0] rd_prio,
  output logic [TID_W:0]    rd_next,
  input  logic              pw_en,
  input  logic [TID_W-1:0]  pw_addr,
  input  logic [PRIO_W-1:0] pw_data,
  input  logic              nw_en,
  input  logic [TID_W-1:0]  nw_addr,
  input  logic [TID_W:0]    nw_data
);
  localparam int DEPTH = 1 << TID_W;

  logic [PRIO_W-1:0] prio_mem [DEPTH];
  logic [TID_W:0]    next_mem [DEPTH];

  // one write port and one synchronous read port per table
  always_ff @(posedge clk) begin
    if (pw_en) prio_mem[pw_addr] <= pw_data;
    rd_prio <= prio_mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (nw_en) next_mem[nw_addr] <= nw_data;
    rd_next <= next_mem[rd_addr];
  end
endmodule

// File: rtl/sched_arb.sv
module sched_arb #(
  parameter int TID_W  = 8,
  parameter int PRIO_W = 7
) (
  input  logic              idle,
  input  logic              mgr_req,
  input  logic              mgr_op,
  input  logic [TID_W-1:0]  mgr_tid,
  input  logic [PRIO_W-1:0] mgr_prio,
  input  logic              host_req,
  input  logic              host_op,
  input  logic [TID_W-1:0]  host_tid,
  input  logic [PRIO_W-1:0] host_prio,
  output logic              go,
  output logic              go_host,
  output logic              go_op,
  output logic [TID_W-1:0]  go_tid,
  output logic [PRIO_W-1:0] go_prio
);
  // manager port has fixed precedence
  always_comb begin
    go      = idle && (mgr_req || host_req);
    go_host = !mgr_req;
    go_op   = mgr_req ? mgr_op   : host_op;
    go_tid  = mgr_req ? mgr_tid  : host_tid;
    go_prio = mgr_req ? mgr_prio : host_prio;
  end
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int TID_W  = 8,
  parameter int PRIO_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_host,
  input  logic              go_op,
  input  logic [TID_W-1:0]  go_tid,
  input  logic [PRIO_W-1:0] go_prio,
  output logic [TID_W-1:0]  rd_addr,
  input  logic [PRIO_W-1:0] rd_prio,
  input  logic [TID_W:0]    rd_next,
  output logic              pw_en,
  output logic [TID_W-1:0]  pw_addr,
  output logic [PRIO_W-1:0] pw_data,
  output logic              nw_en,
  output logic [TID_W-1:0]  nw_addr,
  output logic [TID_W:0]    nw_data,
  output logic              busy,
  output logic              mgr_ack,
  output logic              host_ack,
  output logic              cmd_err,
  output logic [TID_W-1:0]  next_tid,
  output logic [PRIO_W-1:0] next_prio,
  output logic              next_valid
);
  localparam int DEPTH = 1 << TID_W;
  localparam logic [TID_W:0] NIL = {1'b1, {TID_W{1'b0}}};

  sched_state_e      st;
  logic              op_q, src_q, link_need;
  logic [TID_W-1:0]  tid_q, cur, link_addr, best_tid;
  logic [PRIO_W-1:0] prio_q, best_prio;
  logic              best_v;
  logic [TID_W:0]    head, tail, prev;
  logic [DEPTH-1:0]  vld;

  logic is_tgt, take, enq_ok;

  always_comb begin
    is_tgt = (cur == tid_q);
    take   = !is_tgt && (!best_v || (rd_prio < best_prio));
    enq_ok = (op_q == OP_ENQ) && !vld[tid_q];
    rd_addr = (st == ST_CHK) ? head[TID_W-1:0] : rd_next[TID_W-1:0];
    pw_en   = (st == ST_CHK) && enq_ok;
    pw_addr = tid_q;
    pw_data = prio_q;
    nw_en   = 1'b0;
    nw_addr = tid_q;
    nw_data = NIL;
    case (st)
      ST_CHK:  nw_en = enq_ok;
      ST_LINK: begin
        nw_en   = link_need;
        nw_addr = link_addr;
        nw_data = {1'b0, tid_q};
      end
      ST_WALK: begin
        nw_en   = is_tgt && !prev[TID_W];
        nw_addr = prev[TID_W-1:0];
        nw_data = rd_next;
      end
      default: ;
    endcase
  end

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      op_q <= 1'b0; src_q <= 1'b0; tid_q <= '0; prio_q <= '0;
      head <= NIL; tail <= NIL; prev <= NIL;
      cur <= '0; link_addr <= '0; link_need <= 1'b0;
      best_tid <= '0; best_prio <= '0; best_v <= 1'b0;
      vld <= '0;
      next_tid <= '0; next_prio <= '0; next_valid <= 1'b0;
      mgr_ack <= 1'b0; host_ack <= 1'b0; cmd_err <= 1'b0;
    end else begin
      mgr_ack  <= 1'b0;
      host_ack <= 1'b0;
      cmd_err  <= 1'b0;
      case (st)
        ST_IDLE: if (go) begin
          op_q <= go_op; src_q <= go_host; tid_q <= go_tid; prio_q <= go_prio;
          st <= ST_CHK;
        end
        ST_CHK: begin
          if (op_q == OP_ENQ) begin
            if (vld[tid_q]) begin
              st <= ST_IDLE; cmd_err <= 1'b1;
              mgr_ack <= !src_q; host_ack <= src_q;
            end else begin
              vld[tid_q] <= 1'b1;
              link_need <= !head[TID_W];
              link_addr <= tail[TID_W-1:0];
              if (head[TID_W]) head <= {1'b0, tid_q};
              tail <= {1'b0, tid_q};
              if (!next_valid || prio_q < next_prio) begin
                next_tid <= tid_q; next_prio <= prio_q; next_valid <= 1'b1;
              end
              st <= ST_LINK;
            end
          end else begin
            if (!vld[tid_q]) begin
              st <= ST_IDLE; cmd_err <= 1'b1;
              mgr_ack <= !src_q; host_ack <= src_q;
            end else begin
              vld[tid_q] <= 1'b0;
              cur <= head[TID_W-1:0];
              prev <= NIL;
              best_v <= 1'b0;
              st <= ST_WALK;
            end
          end
        end
        ST_LINK: begin
          st <= ST_IDLE;
          mgr_ack <= !src_q; host_ack <= src_q;
        end
        ST_WALK: begin
          if (is_tgt) begin
            if (prev[TID_W]) head <= rd_next;
            if (tail == {1'b0, tid_q}) tail <= prev;
          end else begin
            prev <= {1'b0, cur};
            if (take) begin
              best_tid <= cur; best_prio <= rd_prio; best_v <= 1'b1;
            end
          end
          if (rd_next[TID_W]) begin
            next_tid   <= take ? cur : best_tid;
            next_prio  <= take ? rd_prio : best_prio;
            next_valid <= take || best_v;
            st <= ST_IDLE;
            mgr_ack <= !src_q; host_ack <= src_q;
          end else begin
            cur <= rd_next[TID_W-1:0];
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/thread_ready_sched.sv
module thread_ready_sched #(
  parameter int TID_W  = 8,
  parameter int PRIO_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mgr_req,
  input  logic              mgr_op,
  input  logic [TID_W-1:0]  mgr_tid,
  input  logic [PRIO_W-1:0] mgr_prio,
  output logic              mgr_ack,
  input  logic              host_req,
  input  logic              host_op,
  input  logic [TID_W-1:0]  host_tid,
  input  logic [PRIO_W-1:0] host_prio,
  output logic              host_ack,
  output logic              cmd_err,
  output logic              busy,
  output logic [TID_W-1:0]  next_tid,
  output logic [PRIO_W-1:0] next_prio,
  output logic              next_valid
);
  logic              idle, go, go_host, go_op;
  logic [TID_W-1:0]  go_tid, rd_addr, pw_addr, nw_addr;
  logic [PRIO_W-1:0] go_prio, rd_prio, pw_data;
  logic [TID_W:0]    rd_next, nw_data;
  logic              pw_en, nw_en;

  assign idle = !busy && !mgr_ack && !host_ack;

  sched_arb #(.TID_W(TID_W), .PRIO_W(PRIO_W)) u_arb (
    .idle(idle),
    .mgr_req(mgr_req), .mgr_op(mgr_op), .mgr_tid(mgr_tid), .mgr_prio(mgr_prio),
    .host_req(host_req), .host_op(host_op), .host_tid(host_tid), .host_prio(host_prio),
    .go(go), .go_host(go_host), .go_op(go_op), .go_tid(go_tid), .go_prio(go_prio)
  );

  sched_table #(.TID_W(TID_W), .PRIO_W(PRIO_W)) u_tbl (
    .clk(clk), .rd_addr(rd_addr), .rd_prio(rd_prio), .rd_next(rd_next),
    .pw_en(pw_en), .pw_addr(pw_addr), .pw_data(pw_data),
    .nw_en(nw_en), .nw_addr(nw_addr), .nw_data(nw_data)
  );

  sched_ctrl #(.TID_W(TID_W), .PRIO_W(PRIO_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .go(go), .go_host(go_host), .go_op(go_op), .go_tid(go_tid), .go_prio(go_prio),
    .rd_addr(rd_addr), .rd_prio(rd_prio), .rd_next(rd_next),
    .pw_en(pw_en), .pw_addr(pw_addr), .pw_data(pw_data),
    .nw_en(nw_en), .nw_addr(nw_addr), .nw_data(nw_data),
    .busy(busy), .mgr_ack(mgr_ack), .host_ack(host_ack), .cmd_err(cmd_err),
    .next_tid(next_tid), .next_prio(next_prio), .next_valid(next_valid)
  );
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int TID_W  = 8,
  parameter int PRIO_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              mgr_req,
  input logic              host_req,
  input logic              mgr_ack,
  input logic              host_ack,
  input logic              cmd_err,
  input logic              busy,
  input logic [TID_W-1:0]  next_tid,
  input logic [PRIO_W-1:0] next_prio,
  input logic              next_valid
);
  logic any_ack;
  assign any_ack = mgr_ack || host_ack;

  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    any_ack |=> !any_ack);

  a_r7_ack_not_busy: assert property (@(posedge clk) disable iff (rst)
    any_ack |-> !busy);

  a_r7_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy && !any_ack && (mgr_req || host_req)) |=> busy);

  a_r8_single_port_ack: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mgr_ack, host_ack}));

  a_r4_err_with_ack: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> any_ack);

  a_r1_choice_holds_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> ($stable(next_valid) && $stable(next_tid)
                                 && $stable(next_prio)));
endmodule

bind thread_ready_sched sched_chk #(.TID_W(TID_W), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst(rst), .mgr_req(mgr_req), .host_req(host_req),
  .mgr_ack(mgr_ack), .host_ack(host_ack), .cmd_err(cmd_err), .busy(busy),
  .next_tid(next_tid), .next_prio(next_prio), .next_valid(next_valid)
);

// File: tb/thread_ready_sched_tb_top.sv
`timescale 1ns/1ps
module thread_ready_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mgr_req = 0, mgr_op = 0, host_req = 0, host_op = 0;
  logic [7:0] mgr_tid = 0, host_tid = 0;
  logic [6:0] mgr_prio = 0, host_prio = 0;
  logic       mgr_ack, host_ack, cmd_err, busy, next_valid;
  logic [7:0] next_tid;
  logic [6:0] next_prio;

  int checks = 0;
  int errors = 0;
  int mq[$];
  int mp[256];
  int exp_tid = 0;
  bit exp_v = 0;

  always #4 clk = ~clk;

  thread_ready_sched dut_i (
    .clk(clk), .rst(rst),
    .mgr_req(mgr_req), .mgr_op(mgr_op), .mgr_tid(mgr_tid), .mgr_prio(mgr_prio), .mgr_ack(mgr_ack),
    .host_req(host_req), .host_op(host_op), .host_tid(host_tid), .host_prio(host_prio), .host_ack(host_ack),
    .cmd_err(cmd_err), .busy(busy),
    .next_tid(next_tid), .next_prio(next_prio), .next_valid(next_valid)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int find_idx(input int id);
    foreach (mq[i]) if (mq[i] == id) return i;
    return -1;
  endfunction

  // model update; returns expected error and the edge count at which the ack is due
  task automatic model_cmd(input bit deq, input int id, input int pr, output bit e, output int lat);
    int idx = find_idx(id);
    if (!deq) begin
      e = (idx >= 0);
      lat = e ? 2 : 3;
      if (!e) begin
        mq.push_back(id);
        mp[id] = pr;
        if (!exp_v || pr < mp[exp_tid]) begin exp_tid = id; exp_v = 1; end
      end
    end else begin
      e = (idx < 0);
      lat = e ? 2 : mq.size() + 2;
      if (!e) begin
        mq.delete(idx);
        exp_v = 0;
        foreach (mq[i])
          if (!exp_v || mp[mq[i]] < mp[exp_tid]) begin exp_tid = mq[i]; exp_v = 1; end
      end
    end
  endtask

  task automatic check_next(input string req);
    chk(next_valid == exp_v, req, "next_valid", next_valid, exp_v);
    if (exp_v) begin
      chk(next_tid == exp_tid, req, "next_tid", next_tid, exp_tid);
      chk(next_prio == mp[exp_tid], req, "next_prio", next_prio, mp[exp_tid]);
    end
  endtask

  // wait for the ack on one port, counting edges; n starts from the caller's count
  task automatic wait_ack(input bit host, input int start, output int n, output bit saw_idle);
    n = start;
    saw_idle = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      n++;
      if (host ? host_ack : mgr_ack) return;
      if (!busy && n > start + 1) saw_idle = 1;
    end
    errors++;
    $display("FAIL watchdog: no acknowledge, actual 0 expected 1");
  endtask

  task automatic run_cmd(input bit host, input bit deq, input int id, input int pr, input string req);
    bit e, idle_seen;
    int lat, n;
    model_cmd(deq, id, pr, e, lat);
    if (host) begin host_req = 1; host_op = deq; host_tid = id[7:0]; host_prio = pr[6:0]; end
    else      begin mgr_req = 1;  mgr_op = deq;  mgr_tid = id[7:0];  mgr_prio = pr[6:0];  end
    wait_ack(host, 0, n, idle_seen);
    host_req = 0; mgr_req = 0;
    chk(n == lat, "R9", "ack edge count", n, lat);
    chk(cmd_err == e, req, "cmd_err", cmd_err, e);
    chk(!busy && !idle_seen, "R7", "busy around ack", busy, 0);
    chk((host ? mgr_ack : host_ack) == 0, "R7", "other port ack", 1, 0);
    check_next(req);
    @(negedge clk);
    chk(!mgr_ack && !host_ack, "R7", "ack single pulse", mgr_ack | host_ack, 0);
    check_next(req);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run timeout, actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit e1, e2, idle_seen;
    int l1, l2, n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 / R6 reset state
    chk(!busy && !mgr_ack && !host_ack && !cmd_err, "R10", "reset outputs", busy, 0);
    chk(!next_valid, "R6", "reset next_valid", next_valid, 0);

    run_cmd(0, 1, 5, 0, "R5");       // dequeue from empty list
    run_cmd(0, 0, 10, 5, "R1");
    run_cmd(1, 0, 20, 9, "R1");      // worse priority, choice holds
    run_cmd(0, 0, 30, 2, "R1");      // better, becomes choice
    run_cmd(1, 0, 40, 2, "R2");      // tie, earlier stays
    run_cmd(0, 0, 20, 1, "R4");      // already queued
    run_cmd(0, 1, 30, 0, "R3");      // middle element
    run_cmd(1, 1, 10, 0, "R3");      // head element
    run_cmd(0, 0, 255, 127, "R1");   // widest id and priority
    run_cmd(0, 0, 0, 0, "R1");
    run_cmd(0, 1, 0, 0, "R3");       // tail element
    run_cmd(1, 0, 50, 2, "R3");      // append after tail fix-up
    run_cmd(0, 1, 40, 0, "R3");
    run_cmd(0, 0, 60, 2, "R2");
    run_cmd(1, 1, 20, 0, "R2");      // rescan tie: 50 before 60
    run_cmd(1, 1, 99, 0, "R5");      // absent on non-empty list

    // R8: both ports in the same cycle
    model_cmd(0, 70, 1, e1, l1);
    model_cmd(1, 50, 0, e2, l2);
    mgr_req = 1; mgr_op = 0; mgr_tid = 70; mgr_prio = 1;
    host_req = 1; host_op = 1; host_tid = 50; host_prio = 0;
    wait_ack(0, 0, n, idle_seen);
    mgr_req = 0;
    chk(n == l1 && host_ack == 0, "R8", "manager served first", n, l1);
    wait_ack(1, n, n, idle_seen);
    host_req = 0;
    chk(n == l1 + 1 + l2, "R8", "host served after", n, l1 + 1 + l2);
    chk(cmd_err == e2, "R8", "host cmd_err", cmd_err, e2);
    check_next("R8");
    @(negedge clk);

    // drain to empty
    while (mq.size() > 0) run_cmd(0, 1, mq[0], 0, "R6");
    chk(!next_valid, "R6", "empty next_valid", next_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule